// File: doc/BRIEF.md
# Receive Buffer Resource Ring Manager

This block keeps track of where incoming frames may be stored. Software places a ring of four-word resource descriptors in memory, each giving a buffer base address (two 16-bit words, low first) and that buffer's size in 16-bit words (two more words, low first). The manager fetches a descriptor over a simple word-read memory port and holds the current buffer address and remaining word count. A read pointer walks the ring between a programmable start and end, and a host-owned write pointer marks where software has stopped supplying buffers.

For every frame length offered on the frame port, the manager pads the length (frame bytes plus four check bytes) to the bus granule, either hands out the current buffer address and consumes the space, or refuses the frame when it does not fit. Once the remaining space falls under a programmable end-of-buffer threshold, it moves to the next descriptor, or stops accepting frames when the ring has no descriptor left. Software restarts it by clearing the exhaustion status bit.

Top module: `rx_rsrc_ring`

## Requirements
- R1: After reset the read, start, end, write and upper pointers read 0, the threshold reads 0x02F8, status reads 0, and the block is neither busy nor blocked, with the frame port ready.
- R2: A descriptor fetch reads four 16-bit words at byte addresses {upper, read pointer} + k*2 (16-bit mode) or + k*4 (32-bit mode, `wide_i`=1), k = 0..3; words 0,1 form the buffer address (low, high) and words 2,3 the word count (low, high); the read pointer then advances by 8 bytes (16-bit) or 16 bytes (32-bit).
- R3: If the advanced read pointer equals the end pointer, the read pointer reloads from the start pointer.
- R4: If the read pointer after the advance (and any wrap) equals the write pointer, status bit 5 (exhausted) sets.
- R5: Writes to the start, end, read and write pointers clear bits 1:0 in 32-bit mode and bit 0 in 16-bit mode.
- R6: An accepted frame of L bytes has padded size P = L+4 rounded up to a multiple of 4 (32-bit) or 2 (16-bit); the frame gets the current buffer address, which then advances by P, and the remaining count drops by P/2.
- R7: A frame with P greater than twice the remaining count is refused: status bit 4 sets, buffer address and count stay, and a rollover follows.
- R8: When the remaining count after a frame is below the threshold, or after a refusal, the last-packet flag sets; the block then fetches the next descriptor, or blocks reception if the read pointer equals the write pointer.
- R9: While blocked, offered frames complete as not taken and change neither buffer state nor status.
- R10: Writing status bits as write-one-to-clear; clearing a set bit 5 starts a descriptor fetch and the completed fetch unblocks reception, while clearing only bit 4 starts no fetch.
- R11: A load command starts a fetch; during a fetch `busy_o` is high and `frm_ready_o` is low until the fourth word has been returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_i | input | 1 | 1 selects 32-bit bus granule, 0 selects 16-bit |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select: 0 start, 1 end, 2 read ptr, 3 write ptr, 4 upper, 5 threshold, 6 status |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Readback of the register picked by reg_sel_i |
| load_cmd_i | input | 1 | Pulse: fetch the descriptor at the read pointer |
| mem_req_o | output | 1 | Descriptor word read request |
| mem_addr_o | output | 32 | Byte address of the requested word |
| mem_ack_i | input | 1 | Word returned this cycle |
| mem_data_i | input | 16 | Returned word |
| frm_valid_i | input | 1 | Frame length offered |
| frm_len_i | input | 16 | Frame length in bytes without check bytes |
| frm_ready_o | output | 1 | Frame port can accept |
| frm_done_o | output | 1 | Pulse: a frame was handled |
| frm_taken_o | output | 1 | With frm_done_o: the frame got a buffer |
| frm_base_o | output | 32 | With frm_done_o: address given to the frame |
| cur_addr_o | output | 32 | Current buffer address |
| cur_words_o | output | 32 | Remaining words in current buffer |
| rd_ptr_o | output | 16 | Ring read pointer |
| status_o | output | 16 | Status: bit 4 refused frame, bit 5 exhausted |
| last_pkt_o | output | 1 | Last frame crossed the threshold or was refused |
| blocked_o | output | 1 | Reception blocked |
| busy_o | output | 1 | Descriptor fetch in progress |

## Verification
Frame lengths are swept from one to eight bytes in both bus modes, so every residue of the length against the two-byte and four-byte granules is seen and the two rounding rules are told apart by the address and count steps. A frame that exactly fills the buffer and one that overshoots by two bytes separate the accept and refuse sides of the fit comparison. Descriptor fetches are run with a memory that answers every cycle and one that answers every other cycle, in both strides, with the ring arranged so that one fetch hits the write pointer, one wraps at the end, and a rollover either proceeds or blocks.

// File: rtl/rrm_pkg.sv
// Shared encodings for the receive resource ring manager.
// Assumes 16-bit register and descriptor words.
package rrm_pkg;
    typedef enum logic [2:0] {
        SEL_START  = 3'd0,
        SEL_END    = 3'd1,
        SEL_RDPTR  = 3'd2,
        SEL_WRPTR  = 3'd3,
        SEL_UPPER  = 3'd4,
        SEL_THRESH = 3'd5,
        SEL_STATUS = 3'd6,
        SEL_NONE   = 3'd7
    } rrm_sel_e;

    localparam int HW         = 16; // descriptor / register word width
    localparam int DESC_WORDS = 4;  // words per descriptor
    localparam int STS_BIG    = 4;  // refused-frame status bit
    localparam int STS_EXH    = 5;  // exhausted status bit
endpackage

// File: rtl/rrm_ptr_bank.sv
// Ring pointer registers: start, end, read, write, upper address and
// threshold. Aligns pointer writes to the bus granule and advances the
// read pointer with wrap after each fetch. Assumes wide_i is stable
// while a fetch is running.
module rrm_ptr_bank
    import rrm_pkg::*;
#(
    parameter int          PW      = 16,
    parameter logic [15:0] EOB_RST = 16'h02F8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide_i,
    input  logic          wr_en_i,
    input  logic [2:0]    wr_sel_i,
    input  logic [HW-1:0] wr_data_i,
    input  logic          adv_i,
    output logic [PW-1:0] start_o,
    output logic [PW-1:0] end_o,
    output logic [PW-1:0] rd_o,
    output logic [PW-1:0] wr_o,
    output logic [HW-1:0] upper_o,
    output logic [HW-1:0] thresh_o,
    output logic          adv_meets_wr_o,
    output logic          rd_eq_wr_o
);
    localparam int STEP_N = DESC_WORDS * 2;
    localparam int STEP_W = DESC_WORDS * 4;

    logic [PW-1:0] start_q, end_q, rd_q, wrp_q;
    logic [HW-1:0] upper_q, thresh_q;
    logic [PW-1:0] align_mask, wdata_al, step, adv_sum, adv_nxt;

    // Granule mask, stride and next read pointer with wrap.
    always_comb begin
        align_mask = wide_i ? ~PW'(3) : ~PW'(1);
        wdata_al   = PW'(wr_data_i) & align_mask;
        step       = wide_i ? PW'(STEP_W) : PW'(STEP_N);
        adv_sum    = rd_q + step;
        adv_nxt    = (adv_sum == end_q) ? start_q : adv_sum;
    end

    // Register writes; an advance overrides a same-cycle read pointer write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= '0;
            end_q    <= '0;
            rd_q     <= '0;
            wrp_q    <= '0;
            upper_q  <= '0;
            thresh_q <= EOB_RST;
        end else begin
            if (wr_en_i) begin
                case (wr_sel_i)
                    SEL_START:  start_q  <= wdata_al;
                    SEL_END:    end_q    <= wdata_al;
                    SEL_RDPTR:  rd_q     <= wdata_al;
                    SEL_WRPTR:  wrp_q    <= wdata_al;
                    SEL_UPPER:  upper_q  <= wr_data_i;
                    SEL_THRESH: thresh_q <= wr_data_i;
                    default: ;
                endcase
            end
            if (adv_i) rd_q <= adv_nxt;
        end
    end

    assign start_o        = start_q;
    assign end_o          = end_q;
    assign rd_o           = rd_q;
    assign wr_o           = wrp_q;
    assign upper_o        = upper_q;
    assign thresh_o       = thresh_q;
    assign adv_meets_wr_o = (adv_nxt == wrp_q);
    assign rd_eq_wr_o     = (rd_q == wrp_q);

    // R5: pointers never hold an odd byte address.
    p_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q[0] == 1'b0) && (start_q[0] == 1'b0) && (end_q[0] == 1'b0) && (wrp_q[0] == 1'b0));

    // R3: after an advance the read pointer is either one stride on or the start.
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> (rd_q == $past(start_q)) || (rd_q == $past(rd_q) + $past(step)));
endmodule

// File: rtl/rrm_fetch.sv
// Descriptor fetch sequencer. Issues four word reads at the read pointer
// with a 2- or 4-byte stride, collects the words and presents the buffer
// address and word count in the cycle the last word is acknowledged.
// Assumes start_i is only raised while idle.
module rrm_fetch
    import rrm_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            wide_i,
    input  logic [PW-1:0]   rd_ptr_i,
    input  logic [HW-1:0]   upper_i,
    output logic            mem_req_o,
    output logic [HW+PW-1:0] mem_addr_o,
    input  logic            mem_ack_i,
    input  logic [HW-1:0]   mem_data_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [2*HW-1:0] desc_base_o,
    output logic [2*HW-1:0] desc_words_o
);
    localparam int AW  = HW + PW;
    localparam int IXW = $clog2(DESC_WORDS);

    typedef enum logic {F_IDLE, F_READ} fetch_st_e;

    fetch_st_e      st_q;
    logic [IXW-1:0] idx_q;
    logic [HW-1:0]  w_q [DESC_WORDS];
    logic [AW-1:0]  offs;
    logic           last_word;

    // Byte offset of the current word within the descriptor.
    always_comb begin
        offs      = wide_i ? AW'({idx_q, 2'b00}) : AW'({idx_q, 1'b0});
        last_word = (idx_q == IXW'(DESC_WORDS - 1));
    end

    // Sequencer state and word index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= F_IDLE;
            idx_q <= '0;
        end else if (st_q == F_IDLE) begin
            idx_q <= '0;
            if (start_i) st_q <= F_READ;
        end else if (mem_ack_i) begin
            idx_q <= idx_q + 1'b1;
            if (last_word) st_q <= F_IDLE;
        end
    end

    // Word capture per acknowledged read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DESC_WORDS; i++) w_q[i] <= '0;
        end else if (st_q == F_READ && mem_ack_i) begin
            w_q[idx_q] <= mem_data_i;
        end
    end

    assign mem_req_o    = (st_q == F_READ);
    assign mem_addr_o   = {upper_i, rd_ptr_i} + offs;
    assign busy_o       = (st_q == F_READ);
    assign done_o       = (st_q == F_READ) && mem_ack_i && last_word;
    assign desc_base_o  = {w_q[1], w_q[0]};
    assign desc_words_o = {mem_data_i, w_q[2]};

    // R11: a request stays up until its word is acknowledged.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> mem_req_o);

    // R11: a fetch is never restarted while one runs.
    p_start_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);
endmodule

// File: rtl/rrm_buf_track.sv
// Current buffer tracker. Pads each frame length to the bus granule,
// decides fit, advances the buffer address, shrinks the word count and
// reports when a rollover is needed. Assumes load_i never coincides with
// a frame.
module rrm_buf_track
    import rrm_pkg::*;
#(
    parameter int LW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wide_i,
    input  logic [HW-1:0]   thresh_i,
    input  logic            load_i,
    input  logic [2*HW-1:0] load_base_i,
    input  logic [2*HW-1:0] load_words_i,
    input  logic            fire_i,
    input  logic            drop_i,
    input  logic [LW-1:0]   len_i,
    output logic [2*HW-1:0] cur_addr_o,
    output logic [2*HW-1:0] cur_words_o,
    output logic            fits_o,
    output logic            roll_o,
    output logic            last_o,
    output logic            done_o,
    output logic            taken_o,
    output logic [2*HW-1:0] base_o
);
    localparam int CW   = 2 * HW;
    localparam int PADW = LW + 3;
    localparam int CMPW = ((CW + 1) > PADW) ? (CW + 1) : PADW;

    logic [CW-1:0]   addr_q, words_q, base_q, rem;
    logic [PADW-1:0] rx_len, rx_m1, pad;
    logic            last_q, done_q, taken_q, last_n;

    // Padding, fit test and threshold test for the offered frame.
    always_comb begin
        rx_len = PADW'(len_i) + PADW'(4);
        rx_m1  = rx_len - 1'b1;
        pad    = wide_i ? ((rx_m1 | PADW'(3)) + 1'b1) : ((rx_m1 | PADW'(1)) + 1'b1);
        fits_o = CMPW'(pad) <= (CMPW'(words_q) << 1);
        rem    = words_q - CW'(pad >> 1);
        last_n = fits_o ? (rem < CW'(thresh_i)) : 1'b1;
        roll_o = last_n;
    end

    // Buffer state: descriptor load or frame consumption.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            words_q <= '0;
        end else if (load_i) begin
            addr_q  <= load_base_i;
            words_q <= load_words_i;
        end else if (fire_i && fits_o) begin
            addr_q  <= addr_q + CW'(pad);
            words_q <= rem;
        end
    end

    // Per-frame result and last-packet flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q  <= 1'b0;
            done_q  <= 1'b0;
            taken_q <= 1'b0;
            base_q  <= '0;
        end else begin
            done_q  <= fire_i || drop_i;
            taken_q <= fire_i && fits_o;
            if (fire_i) begin
                base_q <= addr_q;
                last_q <= last_n;
            end
        end
    end

    assign cur_addr_o  = addr_q;
    assign cur_words_o = words_q;
    assign last_o      = last_q;
    assign done_o      = done_q;
    assign taken_o     = taken_q;
    assign base_o      = base_q;

    // R6: an accepted frame strictly reduces the remaining count.
    p_shrink_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && fits_o) |=> cur_words_o < $past(cur_words_o));

    // R7: a refused frame leaves the buffer untouched.
    p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && !fits_o) |=> $stable(cur_addr_o) && $stable(cur_words_o));

    // R11: loads and frames never share a cycle.
    p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && (fire_i || drop_i)));
endmodule

// File: rtl/rx_rsrc_ring.sv
// Receive buffer resource ring manager top. Connects the pointer bank,
// the fetch sequencer and the buffer tracker, owns status, rollover and
// blocking, and gates the frame port. Assumes a single host register port.
module rx_rsrc_ring
    import rrm_pkg::*;
#(
    parameter int          PW      = 16,
    parameter int          LW      = 16,
    parameter logic [15:0] EOB_RST = 16'h02F8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wide_i,
    input  logic             reg_we_i,
    input  logic [2:0]       reg_sel_i,
    input  logic [HW-1:0]    reg_wdata_i,
    output logic [HW-1:0]    reg_rdata_o,
    input  logic             load_cmd_i,
    output logic             mem_req_o,
    output logic [HW+PW-1:0] mem_addr_o,
    input  logic             mem_ack_i,
    input  logic [HW-1:0]    mem_data_i,
    input  logic             frm_valid_i,
    input  logic [LW-1:0]    frm_len_i,
    output logic             frm_ready_o,
    output logic             frm_done_o,
    output logic             frm_taken_o,
    output logic [2*HW-1:0]  frm_base_o,
    output logic [2*HW-1:0]  cur_addr_o,
    output logic [2*HW-1:0]  cur_words_o,
    output logic [PW-1:0]    rd_ptr_o,
    output logic [HW-1:0]    status_o,
    output logic             last_pkt_o,
    output logic             blocked_o,
    output logic             busy_o
);
    localparam int CW = 2 * HW;

    logic [PW-1:0] start_p, end_p, rd_p, wr_p;
    logic [HW-1:0] upper_p, thresh_p;
    logic          adv_meets_wr, rd_eq_wr;
    logic          fetch_busy, fetch_done, fetch_start;
    logic [CW-1:0] desc_base, desc_words;
    logic          fits, roll;
    logic          fire_any, fire, drop;
    logic          roll_pend_q, blocked_q;
    logic          big_q, exh_q;
    logic          sts_wr, clr_big, clr_exh, ptr_wr;

    // Frame handshake split, status clears and fetch trigger.
    always_comb begin
        frm_ready_o = !fetch_busy && !roll_pend_q;
        fire_any    = frm_valid_i && frm_ready_o;
        fire        = fire_any && !blocked_q;
        drop        = fire_any && blocked_q;
        sts_wr      = reg_we_i && (reg_sel_i == SEL_STATUS);
        ptr_wr      = reg_we_i && (reg_sel_i != SEL_STATUS);
        clr_big     = sts_wr && reg_wdata_i[STS_BIG] && big_q;
        clr_exh     = sts_wr && reg_wdata_i[STS_EXH] && exh_q;
        fetch_start = !fetch_busy &&
                      (load_cmd_i || clr_exh || (roll_pend_q && !rd_eq_wr));
    end

    // Rollover request, block state and status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            roll_pend_q <= 1'b0;
            blocked_q   <= 1'b0;
            big_q       <= 1'b0;
            exh_q       <= 1'b0;
        end else begin
            roll_pend_q <= fire && roll;
            if (fetch_done) blocked_q <= 1'b0;
            else if (roll_pend_q && rd_eq_wr) blocked_q <= 1'b1;
            big_q <= (big_q && !clr_big) || (fire && !fits);
            exh_q <= (exh_q && !clr_exh) || (fetch_done && adv_meets_wr);
        end
    end

    rrm_ptr_bank #(.PW(PW), .EOB_RST(EOB_RST)) u_ptrs (
        .clk            (clk),
        .rst_n          (rst_n),
        .wide_i         (wide_i),
        .wr_en_i        (ptr_wr),
        .wr_sel_i       (reg_sel_i),
        .wr_data_i      (reg_wdata_i),
        .adv_i          (fetch_done),
        .start_o        (start_p),
        .end_o          (end_p),
        .rd_o           (rd_p),
        .wr_o           (wr_p),
        .upper_o        (upper_p),
        .thresh_o       (thresh_p),
        .adv_meets_wr_o (adv_meets_wr),
        .rd_eq_wr_o     (rd_eq_wr)
    );

    rrm_fetch #(.PW(PW)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (fetch_start),
        .wide_i       (wide_i),
        .rd_ptr_i     (rd_p),
        .upper_i      (upper_p),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .mem_ack_i    (mem_ack_i),
        .mem_data_i   (mem_data_i),
        .busy_o       (fetch_busy),
        .done_o       (fetch_done),
        .desc_base_o  (desc_base),
        .desc_words_o (desc_words)
    );

    rrm_buf_track #(.LW(LW)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .wide_i       (wide_i),
        .thresh_i     (thresh_p),
        .load_i       (fetch_done),
        .load_base_i  (desc_base),
        .load_words_i (desc_words),
        .fire_i       (fire),
        .drop_i       (drop),
        .len_i        (frm_len_i),
        .cur_addr_o   (cur_addr_o),
        .cur_words_o  (cur_words_o),
        .fits_o       (fits),
        .roll_o       (roll),
        .last_o       (last_pkt_o),
        .done_o       (frm_done_o),
        .taken_o      (frm_taken_o),
        .base_o       (frm_base_o)
    );

    // Status word and register readback.
    always_comb begin
        status_o          = '0;
        status_o[STS_BIG] = big_q;
        status_o[STS_EXH] = exh_q;
        case (reg_sel_i)
            SEL_START:  reg_rdata_o = HW'(start_p);
            SEL_END:    reg_rdata_o = HW'(end_p);
            SEL_RDPTR:  reg_rdata_o = HW'(rd_p);
            SEL_WRPTR:  reg_rdata_o = HW'(wr_p);
            SEL_UPPER:  reg_rdata_o = upper_p;
            SEL_THRESH: reg_rdata_o = thresh_p;
            SEL_STATUS: reg_rdata_o = status_o;
            default:    reg_rdata_o = '0;
        endcase
    end

    assign rd_ptr_o  = rd_p;
    assign blocked_o = blocked_q;
    assign busy_o    = fetch_busy;

    // R11: the frame port is closed while a fetch runs.
    p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !frm_ready_o);

    // R4: exhaustion only appears as the result of a fetch.
    p_exh_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[STS_EXH]) |-> $past(fetch_done));

    // R7: the refused-frame bit only appears after an offered frame.
    p_big_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[STS_BIG]) |-> $past(frm_valid_i));

    // R9: a frame offered while blocked completes without a buffer.
    p_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked_o && frm_valid_i && frm_ready_o) |=> frm_done_o && !frm_taken_o);

    // R10: reception only unblocks when a fetch completes.
    p_unblock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blocked_o) |-> $past(busy_o));
endmodule

// File: tb/rx_rsrc_ring_test.sv
module rx_rsrc_ring_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_i = 1'b0;
    logic        reg_we_i = 1'b0;
    logic [2:0]  reg_sel_i = 3'd7;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic        load_cmd_i = 1'b0;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic        mem_ack_i = 1'b0;
    logic [15:0] mem_data_i = '0;
    logic        frm_valid_i = 1'b0;
    logic [15:0] frm_len_i = '0;
    logic        frm_ready_o, frm_done_o, frm_taken_o;
    logic [31:0] frm_base_o, cur_addr_o, cur_words_o;
    logic [15:0] rd_ptr_o, status_o;
    logic        last_pkt_o, blocked_o, busy_o;

    int tests = 0;
    int fails = 0;
    int bad_upper = 0;
    logic [15:0] exp_upper = 16'h0003;
    logic ack_gap = 1'b0;
    logic [15:0] mem [256];
    logic [31:0] exp_addr, exp_words;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_rsrc_ring uut (.*);

    // Memory model: answers at the falling edge, optionally every other cycle.
    initial begin
        logic phase;
        phase = 1'b0;
        forever begin
            @(negedge clk);
            phase = ~phase;
            mem_ack_i  = mem_req_o && (!ack_gap || phase);
            mem_data_i = mem[mem_addr_o[8:1]];
            if (mem_req_o && mem_addr_o[31:16] != exp_upper) bad_upper++;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog expired");
        fails++;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] sel, input logic [15:0] d);
        reg_sel_i = sel; reg_wdata_i = d; reg_we_i = 1'b1;
        @(negedge clk);
        reg_we_i = 1'b0; reg_sel_i = 3'd7;
    endtask

    task automatic reg_rd(input logic [2:0] sel, output logic [15:0] v);
        reg_sel_i = sel;
        #1;
        v = reg_rdata_o;
        reg_sel_i = 3'd7;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 400 && !frm_ready_o; i++) @(negedge clk);
    endtask

    task automatic put_desc(input int at, input bit wide, input logic [31:0] b, input logic [31:0] w);
        int s;
        s = wide ? 2 : 1;
        mem[(at >> 1) + 0*s] = b[15:0];
        mem[(at >> 1) + 1*s] = b[31:16];
        mem[(at >> 1) + 2*s] = w[15:0];
        mem[(at >> 1) + 3*s] = w[31:16];
    endtask

    function automatic int pad_of(input int len, input bit wide);
        int rx;
        rx = len + 4;
        return wide ? (((rx - 1) | 3) + 1) : (((rx - 1) | 1) + 1);
    endfunction

    task automatic send(input int len, output logic done, output logic taken, output logic [31:0] base);
        frm_len_i = 16'(len); frm_valid_i = 1'b1;
        @(negedge clk);
        frm_valid_i = 1'b0;
        done = frm_done_o; taken = frm_taken_o; base = frm_base_o;
        @(negedge clk);
        wait_ready();
    endtask

    task automatic fetch_cmd(input string tag);
        load_cmd_i = 1'b1;
        @(negedge clk);
        load_cmd_i = 1'b0;
        chk({tag, " R11 busy during fetch"}, 32'(busy_o), 1);
        chk({tag, " R11 port closed during fetch"}, 32'(frm_ready_o), 0);
        wait_ready();
    endtask

    initial begin
        logic [15:0] v;
        logic d, t;
        logic [31:0] b;
        for (int i = 0; i < 256; i++) mem[i] = 16'hDEAD;
        // 16-bit ring: start 0x40, end 0x58, write ptr 0x50.
        put_desc(32'h40, 0, 32'h0001_2000, 32'h400);
        put_desc(32'h48, 0, 32'h0001_3000, 32'h10);
        put_desc(32'h50, 0, 32'h0001_4000, 32'h300);
        // 32-bit ring: start 0x80, end 0xA0, write ptr 0x90.
        put_desc(32'h80, 1, 32'h0001_5000, 32'h10);
        put_desc(32'h90, 1, 32'h0001_6000, 32'h200);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_rd(3'd2, v); chk("R1 read ptr", 32'(v), 0);
        reg_rd(3'd0, v); chk("R1 start", 32'(v), 0);
        reg_rd(3'd5, v); chk("R1 threshold", 32'(v), 32'h02F8);
        reg_rd(3'd6, v); chk("R1 status", 32'(v), 0);
        chk("R1 busy", 32'(busy_o), 0);
        chk("R1 blocked", 32'(blocked_o), 0);
        chk("R1 ready", 32'(frm_ready_o), 1);

        // R5 alignment masking
        reg_wr(3'd2, 16'h0107); reg_rd(3'd2, v); chk("R5 16-bit mask", 32'(v), 32'h0106);
        wide_i = 1'b1;
        reg_wr(3'd2, 16'h0107); reg_rd(3'd2, v); chk("R5 32-bit mask", 32'(v), 32'h0104);
        reg_wr(3'd3, 16'h00F3); reg_rd(3'd3, v); chk("R5 32-bit mask wr ptr", 32'(v), 32'h00F0);
        wide_i = 1'b0;

        reg_wr(3'd0, 16'h0040);
        reg_wr(3'd1, 16'h0058);
        reg_wr(3'd3, 16'h0050);
        reg_wr(3'd2, 16'h0040);
        reg_wr(3'd4, exp_upper);

        // R2 first fetch, 16-bit stride
        fetch_cmd("first");
        chk("R2 buffer address", cur_addr_o, 32'h0001_2000);
        chk("R2 word count", cur_words_o, 32'h400);
        chk("R2 read ptr step 8", 32'(rd_ptr_o), 32'h48);
        chk("R4 no exhaustion", 32'(status_o), 0);
        exp_addr = 32'h0001_2000; exp_words = 32'h400;

        // R6 sweep lengths in both modes
        for (int m = 0; m < 2; m++) begin
            wide_i = (m == 1);
            for (int len = 1; len <= 8; len++) begin
                int p;
                p = pad_of(len, m == 1);
                send(len, d, t, b);
                chk($sformatf("R6 done m%0d len%0d", m, len), 32'(d & t), 1);
                chk($sformatf("R6 base m%0d len%0d", m, len), b, exp_addr);
                exp_addr = exp_addr + 32'(p);
                exp_words = exp_words - 32'(p / 2);
                chk($sformatf("R6 addr m%0d len%0d", m, len), cur_addr_o, exp_addr);
                chk($sformatf("R6 words m%0d len%0d", m, len), cur_words_o, exp_words);
                chk($sformatf("R8 no last m%0d len%0d", m, len), 32'(last_pkt_o), 0);
            end
        end
        wide_i = 1'b0;

        // R8 threshold crossing, rollover fetch that reaches the write ptr (R4)
        reg_wr(3'd5, 16'(exp_words - 2));
        send(4, d, t, b);
        chk("R8 frame taken", 32'(t), 1);
        chk("R8 last flag", 32'(last_pkt_o), 1);
        chk("R8 next buffer", cur_addr_o, 32'h0001_3000);
        chk("R8 next count", cur_words_o, 32'h10);
        chk("R2 read ptr to 0x50", 32'(rd_ptr_o), 32'h50);
        chk("R4 exhausted bit 5", 32'(status_o), 32'h20);
        chk("R8 not blocked", 32'(blocked_o), 0);

        // R7 refusal: 29 bytes pads to 34 > 32
        send(29, d, t, b);
        chk("R7 done", 32'(d), 1);
        chk("R7 not taken", 32'(t), 0);
        chk("R7 status bit 4", 32'(status_o), 32'h30);
        chk("R7 address kept", cur_addr_o, 32'h0001_3000);
        chk("R7 count kept", cur_words_o, 32'h10);
        chk("R8 blocked at write ptr", 32'(blocked_o), 1);

        // R9 drop while blocked
        send(4, d, t, b);
        chk("R9 done", 32'(d), 1);
        chk("R9 not taken", 32'(t), 0);
        chk("R9 address kept", cur_addr_o, 32'h0001_3000);
        chk("R9 count kept", cur_words_o, 32'h10);
        chk("R9 status kept", 32'(status_o), 32'h30);

        // R10 clear bit 4 only: no fetch
        reg_wr(3'd6, 16'h0010);
        @(negedge clk);
        chk("R10 bit4 cleared", 32'(status_o), 32'h20);
        chk("R10 no fetch", 32'(busy_o), 0);
        chk("R10 still blocked", 32'(blocked_o), 1);
        chk("R10 read ptr kept", 32'(rd_ptr_o), 32'h50);

        // R10 clear bit 5: fetch, wrap at end (R3), unblock
        reg_wr(3'd6, 16'h0020);
        chk("R10 fetch started", 32'(busy_o), 1);
        wait_ready();
        chk("R10 buffer", cur_addr_o, 32'h0001_4000);
        chk("R10 count", cur_words_o, 32'h300);
        chk("R3 wrapped to start", 32'(rd_ptr_o), 32'h40);
        chk("R10 status clear", 32'(status_o), 0);
        chk("R10 unblocked", 32'(blocked_o), 0);

        // 32-bit ring with wait states
        wide_i = 1'b1; ack_gap = 1'b1;
        reg_wr(3'd0, 16'h0080);
        reg_wr(3'd1, 16'h00A0);
        reg_wr(3'd3, 16'h0090);
        reg_wr(3'd2, 16'h0080);
        reg_wr(3'd5, 16'h02F8);
        fetch_cmd("wide");
        chk("R2 wide buffer", cur_addr_o, 32'h0001_5000);
        chk("R2 wide count", cur_words_o, 32'h10);
        chk("R2 wide step 16", 32'(rd_ptr_o), 32'h90);
        chk("R4 wide exhausted", 32'(status_o), 32'h20);

        // R7 boundary: 28 bytes pads to exactly 32
        send(28, d, t, b);
        chk("R7 exact fit taken", 32'(t), 1);
        chk("R7 exact fit base", b, 32'h0001_5000);
        chk("R6 exact fit addr", cur_addr_o, 32'h0001_5020);
        chk("R6 exact fit words", cur_words_o, 0);
        chk("R8 wide last", 32'(last_pkt_o), 1);
        chk("R8 wide blocked", 32'(blocked_o), 1);

        reg_wr(3'd6, 16'h0020);
        wait_ready();
        chk("R3 wide wrap", 32'(rd_ptr_o), 32'h80);
        chk("R2 wide second buffer", cur_addr_o, 32'h0001_6000);
        chk("R2 wide second count", cur_words_o, 32'h200);
        chk("R10 wide status", 32'(status_o), 0);
        chk("R10 wide unblocked", 32'(blocked_o), 0);

        chk("R2 upper address bits", 32'(bad_upper), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule